// File: doc/BRIEF.md
# Line Loss-of-Signal Detector with Receive Data Muting

This block sits in a receive path after clock and data recovery. The recovered serial line arrives as words of eight bits, one word per clock, with a valid qualifier. The block watches the bit stream for a dead line. A long unbroken run of zero bits raises a loss indication. The indication falls only after the line shows enough activity, which is measured as a count of bit-to-bit transitions over a sliding window of recent bits. Because raising and clearing use different criteria, the indication has hysteresis. Short bursts of noise on a dead line do not make it toggle.

While loss is indicated, the parallel receive word is replaced by zeros. An optical module's active-low signal-detect input can also zero the data on its own, whatever the internal detector says. A static disable input switches off the internal detector and its automatic muting. The external forcing still applies while the block is disabled. Both outputs are registered.

Top module: `sigloss_guard`

## Requirements
- R1: While reset is held, and in the cycles after its release until the first valid word, `los_o` is 1 and `rx_data_o` is all zeros.
- R2: Loss is declared when 128 consecutive zero bits have been seen. Bits are taken LSB first within a word, and the run continues across word boundaries. `los_o` rises on the clock edge that follows the word that completes the run.
- R3: Any one bit restarts the zero run. A run that reaches 127 zeros and then meets a one does not declare loss.
- R4: When loss is active, it clears on the edge after a word that brings the transition count to 16 or more. The count covers the last 128 bits, which is the last 16 valid words. A transition is a change between adjacent bits, including the change from bit 7 of the previous valid word to bit 0 of the current one.
- R5: While the count over the last 128 bits stays below 16, loss stays active. Transitions older than 128 bits no longer count.
- R6: `rx_data_o` is the input word registered once. It is all zeros when the loss state after that word is active. Otherwise it equals the input word.
- R7: While `mon_dis_i` is 1, `los_o` is 0 from the next edge on and words are not muted by the internal detector. The run and window state keep tracking the line.
- R8: While `sig_det_n_i` is 0, `rx_data_o` becomes all zeros on the next edge, whether or not a word is valid. `los_o` does not react to this input.
- R9: In a cycle with `rx_valid_i` at 0, the zero run, the transition window, `los_o` and `rx_data_o` all hold. The one exception is the forced zero of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Input word qualifier |
| rx_data_i | input | 8 | Recovered line bits, bit 0 first on the line |
| mon_dis_i | input | 1 | 1 = internal detection and muting off |
| sig_det_n_i | input | 1 | External signal detect, 0 forces zero data |
| rx_data_o | output | 8 | Registered, possibly muted receive word |
| los_o | output | 1 | Registered internal loss indication |

## Verification
Two events can land on the same edge: the external forced zero and the internal clear of loss. In that cycle `los_o` must fall while `rx_data_o` stays zero, because the external input still holds the data. The bench provokes this by pulling `sig_det_n_i` low at random while transition-rich words are clearing a declared loss. It also does this while 0x80/0x00 boundary patterns are finishing their sixteenth transition. A bit-level reference model judges each cycle, and it applies the external forcing after the loss update. The flag and the data are therefore checked against separate expected values.

// File: rtl/sigloss_pkg.sv
package sigloss_pkg;

  typedef enum logic {
    SIG_OK   = 1'b0,
    SIG_LOST = 1'b1
  } sig_state_e;

endpackage

// File: rtl/sigloss_rst_sync.sv
module sigloss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/sigloss_zero_run.sv
module sigloss_zero_run #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned RUN_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o
);

  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);
  localparam int unsigned EXT_W = $clog2(RUN_LIMIT + WORD_W + 1);
  localparam int unsigned POS_W = $clog2(WORD_W + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic [POS_W-1:0] lsb_zeros, msb_zeros;
  logic [EXT_W-1:0] lead_sum;

  // zeros before the first one (line order) and after the last one
  always_comb begin
    lsb_zeros = POS_W'(WORD_W);
    msb_zeros = POS_W'(WORD_W);
    for (int i = int'(WORD_W) - 1; i >= 0; i--) begin
      if (word_i[i]) lsb_zeros = POS_W'(i);
    end
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (word_i[i]) msb_zeros = POS_W'(int'(WORD_W) - 1 - i);
    end
  end

  always_comb begin
    lead_sum = EXT_W'(run_q) + EXT_W'(lsb_zeros);
    hit_o    = (lead_sum >= EXT_W'(RUN_LIMIT));
    run_d    = run_q;
    if (en) begin
      if (word_i == '0) begin
        if (lead_sum >= EXT_W'(RUN_LIMIT)) run_d = RUN_W'(RUN_LIMIT);
        else                               run_d = RUN_W'(lead_sum);
      end else begin
        run_d = RUN_W'(msb_zeros);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R2
  run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_LIMIT));

  // R3
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && word_i != '0) |=> (run_q < RUN_W'(WORD_W)));

  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(run_q));

endmodule

// File: rtl/sigloss_trans_window.sv
module sigloss_trans_window #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned WIN_BITS = 128,
  parameter int unsigned SUM_W    = $clog2(WIN_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] word_i,
  output logic [SUM_W-1:0]  sum_nxt_o
);

  localparam int unsigned WIN_WORDS = WIN_BITS / WORD_W;
  localparam int unsigned CNT_W     = $clog2(WORD_W + 1);

  logic              last_q, last_d;
  logic [WORD_W-1:0] flips;
  logic [CNT_W-1:0]  new_cnt;
  logic [SUM_W-1:0]  sum_q, sum_d;
  logic [CNT_W-1:0]  hist_q [WIN_WORDS];

  always_comb begin
    flips   = word_i ^ {word_i[WORD_W-2:0], last_q};
    new_cnt = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      new_cnt = new_cnt + CNT_W'(flips[i]);
    end
    sum_nxt_o = sum_q + SUM_W'(new_cnt) - SUM_W'(hist_q[WIN_WORDS-1]);
    sum_d     = en ? sum_nxt_o : sum_q;
    last_d    = en ? word_i[WORD_W-1] : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      last_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      last_q <= last_d;
    end
  end

  for (genvar g = 0; g < int'(WIN_WORDS); g++) begin : g_hist
    logic [CNT_W-1:0] stage_in;
    if (g == 0) begin : g_head
      assign stage_in = new_cnt;
    end else begin : g_body
      assign stage_in = hist_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hist_q[g] <= '0;
      else if (en) hist_q[g] <= stage_in;
    end
  end

  // R5
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SUM_W'(WIN_BITS));

  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sum_q) && $stable(last_q)));

endmodule

// File: rtl/sigloss_guard.sv
module sigloss_guard
  import sigloss_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned RUN_LIMIT = 128,
  parameter int unsigned WIN_BITS  = 128,
  parameter int unsigned CLR_TRANS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic              mon_dis_i,
  input  logic              sig_det_n_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              los_o
);

  localparam int unsigned SUM_W = $clog2(WIN_BITS + 1);

  logic              rst_s_n;
  logic              run_hit;
  logic [SUM_W-1:0]  win_sum;
  sig_state_e        state_q, state_d;
  logic [WORD_W-1:0] data_q, data_d;

  sigloss_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sigloss_zero_run #(
    .WORD_W    (WORD_W),
    .RUN_LIMIT (RUN_LIMIT)
  ) u_zero_run (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .en     (rx_valid_i),
    .word_i (rx_data_i),
    .hit_o  (run_hit)
  );

  sigloss_trans_window #(
    .WORD_W   (WORD_W),
    .WIN_BITS (WIN_BITS),
    .SUM_W    (SUM_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .en        (rx_valid_i),
    .word_i    (rx_data_i),
    .sum_nxt_o (win_sum)
  );

  // loss state: declare on zero run, clear on window activity
  always_comb begin
    state_d = state_q;
    if (mon_dis_i) begin
      state_d = SIG_OK;
    end else if (rx_valid_i) begin
      if (state_q == SIG_LOST) begin
        if (win_sum >= SUM_W'(CLR_TRANS)) state_d = SIG_OK;
      end else if (run_hit) begin
        state_d = SIG_LOST;
      end
    end
  end

  // data path: external force, then internal mute, else pass
  always_comb begin
    data_d = data_q;
    if (!sig_det_n_i)                 data_d = '0;
    else if (rx_valid_i) begin
      if (state_d == SIG_LOST)        data_d = '0;
      else                            data_d = rx_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= SIG_LOST;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  assign los_o     = (state_q == SIG_LOST);
  assign rx_data_o = data_q;

  // R6
  los_mute_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    los_o |-> (rx_data_o == '0));

  // R7
  dis_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mon_dis_i |=> !los_o);

  // R7
  dis_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mon_dis_i && rx_valid_i && sig_det_n_i) |=> (rx_data_o == $past(rx_data_i)));

  // R8
  ext_force_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !sig_det_n_i |=> (rx_data_o == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!rx_valid_i && sig_det_n_i && !mon_dis_i) |=> ($stable(rx_data_o) && $stable(los_o)));

endmodule

// File: tb/test_sigloss_guard.sv
module test_sigloss_guard;

  localparam int W    = 8;
  localparam int WIN  = 128;
  localparam int RUN  = 128;
  localparam int CLR  = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid;
  logic [W-1:0] din;
  logic         dis;
  logic         sdn;
  logic [W-1:0] dout;
  logic         los;

  int checks = 0;
  int failures = 0;
  int unused_seed;

  logic [WIN-1:0] m_flags;
  logic           m_last;
  int             m_run;
  logic           m_los;
  logic [W-1:0]   m_data;

  always #5 clk = ~clk;

  sigloss_guard i_sigloss_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid_i  (valid),
    .rx_data_i   (din),
    .mon_dis_i   (dis),
    .sig_det_n_i (sdn),
    .rx_data_o   (dout),
    .los_o       (los)
  );

  task automatic model_step(input logic [W-1:0] d, input logic v, input logic ds, input logic sd);
    logic hit;
    logic b;
    if (v) begin
      hit = 1'b0;
      for (int i = 0; i < W; i++) begin
        b       = d[i];
        m_flags = {m_flags[WIN-2:0], b ^ m_last};
        m_last  = b;
        if (b) m_run = 0;
        else if (m_run < RUN) m_run++;
        if (m_run >= RUN) hit = 1'b1;
      end
      if (m_los) m_los = !($countones(m_flags) >= CLR);
      else       m_los = hit;
    end
    if (ds) m_los = 1'b0;
    if (!sd)    m_data = '0;
    else if (v) m_data = m_los ? '0 : d;
  endtask

  task automatic check(input string tag);
    checks++;
    if (los !== m_los || dout !== m_data) begin
      failures++;
      $display("FAIL %s: los=%0b data=%02h expected los=%0b data=%02h",
               tag, los, dout, m_los, m_data);
    end
  endtask

  function automatic string auto_tag(input logic v, input logic ds, input logic sd,
                                     input logic was, input logic now);
    if (!sd)             return "R8";
    if (ds)              return "R7";
    if (!v)              return "R9";
    if (!was && now)     return "R2";
    if (was && !now)     return "R4";
    if (was)             return "R5";
    return "R6";
  endfunction

  task automatic step(input logic [W-1:0] d, input logic v, input logic ds,
                      input logic sd, input string tag);
    logic was;
    was   = m_los;
    din   = d;
    valid = v;
    dis   = ds;
    sdn   = sd;
    model_step(d, v, ds, sd);
    @(posedge clk);
    #2;
    if (tag == "") check(auto_tag(v, ds, sd, was, m_los));
    else           check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'd4711);
    m_flags = '0; m_last = 1'b0; m_run = 0; m_los = 1'b1; m_data = '0;
    rst_n = 1'b0; valid = 1'b0; din = 8'hA5; dis = 1'b0; sdn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1");

    // clear from reset: 8 transitions per 0x55 word
    step(8'h55, 1, 0, 1, "R5");
    step(8'h55, 1, 0, 1, "R4");
    // declare after 128 zeros spanning words
    for (int i = 0; i < 15; i++) step(8'h00, 1, 0, 1, "R2");
    step(8'h00, 1, 0, 1, "R2");
    step(8'h00, 1, 0, 1, "R2");
    // clear again, then a run of 127 broken by a one
    step(8'h55, 1, 0, 1, "R4");
    step(8'h55, 1, 0, 1, "R4");
    for (int i = 0; i < 15; i++) step(8'h00, 1, 0, 1, "R3");
    step(8'h40, 1, 0, 1, "R3");
    step(8'h3C, 1, 0, 1, "R6");
    // declare, then too few transitions and aging
    for (int i = 0; i < 17; i++) step(8'h00, 1, 0, 1, "R2");
    for (int i = 0; i < 7; i++)  step(8'h01, 1, 0, 1, "R5");
    for (int i = 0; i < 16; i++) step(8'h00, 1, 0, 1, "R5");
    step(8'h01, 1, 0, 1, "R5");
    // word boundary transitions only: 0x80 then 0x00
    for (int i = 0; i < 8; i++) begin
      step(8'h80, 1, 0, 1, "R4");
      step(8'h00, 1, 0, 1, "R4");
    end
    step(8'hC3, 1, 0, 1, "R6");
    // monitoring disabled across a dead line
    for (int i = 0; i < 20; i++) step(8'h00, 1, 1, 1, "R7");
    step(8'h5A, 1, 1, 1, "R7");
    step(8'h00, 1, 0, 1, "R2");
    // external forcing, also with no valid word
    step(8'hFF, 1, 0, 0, "R8");
    step(8'h55, 0, 0, 0, "R8");
    step(8'h55, 1, 0, 1, "R4");
    step(8'h5A, 1, 0, 1, "R6");
    // idle words do not move anything
    for (int i = 0; i < 5; i++) step(8'h00, 0, 0, 1, "R9");
    step(8'h99, 1, 0, 1, "R6");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic [W-1:0] d;
      logic v, ds, sd;
      int r;
      r = int'($urandom % 10);
      if (r < 5)      d = 8'h00;
      else if (r < 7) d = 8'(1 << ($urandom % 8));
      else if (r < 9) d = ($urandom % 2) ? 8'h55 : 8'h80;
      else            d = 8'($urandom);
      v  = ($urandom % 100) < 85;
      ds = ((n / 500) % 5 == 4) && (($urandom % 4) != 0);
      sd = ($urandom % 100) >= 6;
      step(d, v, ds, sd, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule